// File: doc/BRIEF.md
# DMA Channel Context Identifier Bank

This block holds one 32-bit context identifier per DMA channel. Each identifier records which software process owns the channel. Its low byte is the address-space identifier (ASID), which downstream translation logic uses to choose the right virtual-to-physical mapping. The upper 24 bits carry the rest of the process identity. Software never addresses a channel's identifier directly. It first writes a channel-number register, and every later identifier access lands on the channel that register names.

Each request carries the requester's security state and privilege level. A permission check turns every access into either a grant or an undefined-instruction fault. A chip-level enable bit decides whether non-secure privileged code may use the block at all. The same check covers both the channel-number register and the identifier registers. A granted identifier write is silently dropped while the selected channel is running or queued, so a live transfer can never see its owner change.

Responses come from a three-state machine. ST_IDLE means no request was accepted last cycle. ST_GRANT means the last request passed the permission check. ST_DENY means the last request was refused. In every state the next state is chosen the same way: no request leads to ST_IDLE, a permitted request leads to ST_GRANT, and a refused request leads to ST_DENY. Requests can therefore arrive back to back, and each one gets exactly one response cycle.

Top module: `ctxid_bank`

## Requirements
- R1: After reset every identifier register and the channel-number register read as zero, `asid_out` is zero, and `rsp_valid`/`rsp_fault` are low.
- R2: A request with `req_priv`=0 always faults: `rsp_fault`=1, `rsp_rdata`=0, and no register changes.
- R3: A request with `req_priv`=1 and `req_secure`=1 is always granted, whatever the value of `ns_dma_en`.
- R4: A request with `req_priv`=1 and `req_secure`=0 is granted when `ns_dma_en`=1. It faults when `ns_dma_en`=0, and the fault leaves state unchanged.
- R5: A request accepted at one clock edge yields `rsp_valid`=1 for exactly the following cycle. `rsp_fault` is a one-cycle pulse per refused request. `rsp_rdata` is zero for writes, for faults and when `rsp_valid`=0.
- R6: A granted identifier write takes effect at the accepting edge. A read of the same channel issued in the next cycle returns the new value.
- R7: A granted identifier write (`req_tgt`=0) is ignored when `chan_active` bit N is 1, where N is the selected channel. Such a write still returns a normal, non-faulting response.
- R8: `req_tgt`=1 addresses the channel-number register. A granted write loads `req_wdata[SEL_W-1:0]`, a granted read returns that value zero-extended, and later identifier accesses address the channel it names.
- R9: When the channel number is at least `N_CHAN`, identifier reads return zero, identifier writes change nothing, neither faults, and `asid_out` is zero.
- R10: `asid_out` always equals bits [7:0] of the identifier of the currently selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt | input | 1 | 0 = context identifier of selected channel, 1 = channel-number register |
| req_secure | input | 1 | Requester is in the secure state |
| req_priv | input | 1 | Requester is privileged |
| req_wdata | input | 32 | Write data |
| ns_dma_en | input | 1 | Permits non-secure privileged access |
| chan_active | input | N_CHAN | Per-channel running-or-queued status |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_fault | output | 1 | Undefined-instruction fault for that request |
| rsp_rdata | output | 32 | Read data, zero unless a granted read |
| asid_out | output | 8 | ASID of the selected channel |

## Verification
The bench first checks the permission matrix. It toggles `ns_dma_en` under secure and non-secure privileged requests, and follows every refused write with a read. A design that ignored the enable bit for secure requests, or let a faulting write through, shows a wrong grant or a changed value there. Further checks cover the write that lands on a busy channel and the read issued one cycle after a write. A design that sampled the wrong channel's status would drop the wrong write, and one that bypassed or delayed the register would return stale data. The last checks select an unimplemented channel number and then reselect real channels. A design that aliased the high channel numbers onto real channels would change a real channel's identifier or `asid_out`, and one that faulted on them would assert `rsp_fault`.

// File: rtl/ctxid_pkg.sv
package ctxid_pkg;
    localparam int CTX_W  = 32;
    localparam int ASID_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } rsp_state_e;

    typedef enum logic {
        TGT_CTXID = 1'b0,
        TGT_CHNUM = 1'b1
    } tgt_e;
endpackage

// File: rtl/ctxid_perm.sv
module ctxid_perm (
    input  logic is_secure,
    input  logic is_priv,
    input  logic ns_enable,
    output logic allow
);
    // Unprivileged: always refused. Secure privileged: always allowed.
    // Non-secure privileged: allowed only under the global enable.
    always_comb begin
        if (!is_priv)
            allow = 1'b0;
        else if (is_secure)
            allow = 1'b1;
        else
            allow = ns_enable;
    end
endmodule

// File: rtl/ctxid_store.sv
module ctxid_store #(
    parameter int N_CHAN = 4,
    parameter int SEL_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              sel,
    input  logic [ctxid_pkg::CTX_W-1:0]   wr_data,
    input  logic [N_CHAN-1:0]             active,
    output logic [ctxid_pkg::CTX_W-1:0]   rd_data,
    output logic                          sel_hit,
    output logic                          sel_busy
);
    import ctxid_pkg::*;

    logic [CTX_W-1:0] ctx_q [N_CHAN];
    logic [N_CHAN-1:0] match;

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        assign match[g] = (sel == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctx_q[g] <= '0;
            else if (wr_en && match[g] && !active[g])
                ctx_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data  = '0;
        sel_busy = 1'b0;
        for (int i = 0; i < N_CHAN; i++) begin
            if (match[i]) begin
                rd_data  = ctx_q[i];
                sel_busy = active[i];
            end
        end
    end

    assign sel_hit = |match;
endmodule

// File: rtl/ctxid_rsp_fsm.sv
module ctxid_rsp_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_allow,
    output logic rsp_valid,
    output logic rsp_fault
);
    import ctxid_pkg::*;

    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (!req_valid)     state_d = ST_IDLE;
                else if (req_allow) state_d = ST_GRANT;
                else                state_d = ST_DENY;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: rsp_valid = 1'b1;
            ST_DENY:  begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/ctxid_bank.sv
module ctxid_bank #(
    parameter int N_CHAN = 4,
    parameter int SEL_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_tgt,
    input  logic                req_secure,
    input  logic                req_priv,
    input  logic [31:0]         req_wdata,
    input  logic                ns_dma_en,
    input  logic [N_CHAN-1:0]   chan_active,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [31:0]         rsp_rdata,
    output logic [7:0]          asid_out
);
    import ctxid_pkg::*;

    localparam int PAD_W = CTX_W - SEL_W;

    logic             allow;
    logic [SEL_W-1:0] chan_q;
    logic [CTX_W-1:0] cur_ctx;
    logic             cur_hit;
    logic             cur_busy;
    logic             ctx_wr;
    logic [CTX_W-1:0] rdata_d, rdata_q;
    logic             granted;

    ctxid_perm u_perm (
        .is_secure (req_secure),
        .is_priv   (req_priv),
        .ns_enable (ns_dma_en),
        .allow     (allow)
    );

    assign granted = req_valid && allow;
    assign ctx_wr  = granted && req_write && (req_tgt == TGT_CTXID) && cur_hit;

    ctxid_store #(.N_CHAN(N_CHAN), .SEL_W(SEL_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctx_wr),
        .sel      (chan_q),
        .wr_data  (req_wdata),
        .active   (chan_active),
        .rd_data  (cur_ctx),
        .sel_hit  (cur_hit),
        .sel_busy (cur_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chan_q <= '0;
        else if (granted && req_write && (req_tgt == TGT_CHNUM))
            chan_q <= req_wdata[SEL_W-1:0];
    end

    always_comb begin
        rdata_d = '0;
        if (granted && !req_write) begin
            if (req_tgt == TGT_CHNUM) rdata_d = {{PAD_W{1'b0}}, chan_q};
            else                      rdata_d = cur_ctx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    ctxid_rsp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_allow (allow),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault)
    );

    assign rsp_rdata = rdata_q;
    assign asid_out  = cur_ctx[ASID_W-1:0];
endmodule

// File: rtl/ctxid_bank_chk.sv
module ctxid_bank_chk #(
    parameter int N_CHAN = 4,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_tgt,
    input logic              req_secure,
    input logic              req_priv,
    input logic              ns_dma_en,
    input logic [N_CHAN-1:0] chan_active,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [31:0]       rsp_rdata,
    input logic [7:0]        asid_out,
    input logic [SEL_W-1:0]  chan_q
);
    logic sel_active;
    always_comb begin
        sel_active = 1'b0;
        for (int i = 0; i < N_CHAN; i++)
            if (chan_q == SEL_W'(i)) sel_active = chan_active[i];
    end

    // R5
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R5
    no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_fault);
    // R5
    fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid && (rsp_rdata == 32'd0));
    // R2
    user_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv) |=> rsp_fault);
    // R3
    secure_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && req_secure) |=> !rsp_fault);
    // R4
    ns_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && !req_secure) |=> (rsp_fault == !$past(ns_dma_en)));
    // R7
    busy_write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_tgt && sel_active) |=> $stable(asid_out));
    // R5
    write_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0));
endmodule

bind ctxid_bank ctxid_bank_chk #(.N_CHAN(N_CHAN), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_tgt     (req_tgt),
    .req_secure  (req_secure),
    .req_priv    (req_priv),
    .ns_dma_en   (ns_dma_en),
    .chan_active (chan_active),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_rdata   (rsp_rdata),
    .asid_out    (asid_out),
    .chan_q      (chan_q)
);

// File: tb/tb_ctxid_bank.sv
`timescale 1ns/1ps
module tb_ctxid_bank;
    localparam int N_CHAN = 4;
    localparam int SEL_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_tgt = 1'b0;
    logic              req_secure = 1'b0, req_priv = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              ns_dma_en = 1'b0;
    logic [N_CHAN-1:0] chan_active = '0;
    logic              rsp_valid, rsp_fault;
    logic [31:0]       rsp_rdata;
    logic [7:0]        asid_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ctxid_bank #(.N_CHAN(N_CHAN), .SEL_W(SEL_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_tgt(req_tgt), .req_secure(req_secure), .req_priv(req_priv),
        .req_wdata(req_wdata), .ns_dma_en(ns_dma_en), .chan_active(chan_active),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .asid_out(asid_out)
    );

    typedef struct packed {
        logic        wr;
        logic        tgt;
        logic        sec;
        logic        priv;
        logic        ns;
        logic [3:0]  act;
        logic [31:0] wd;
        logic        ef;
        logic [31:0] ed;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b1,1'b1,1'b0,4'h0,32'h12345678,1'b0,32'h0,4'd3},        // R3 secure write
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,32'h0,1'b0,32'h12345678,4'd6},        // R6 read back
        '{1'b0,1'b0,1'b1,1'b0,1'b1,4'h0,32'h0,1'b1,32'h0,4'd2},               // R2 user read
        '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h0,32'hDEADBEEF,1'b1,32'h0,4'd2},        // R2 user write
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,32'h0,1'b0,32'h12345678,4'd2},        // R2 unchanged
        '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,32'h0,1'b1,32'h0,4'd4},               // R4 ns read off
        '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,32'hAAAA0001,1'b1,32'h0,4'd4},        // R4 ns write off
        '{1'b0,1'b0,1'b0,1'b1,1'b1,4'h0,32'h0,1'b0,32'h12345678,4'd4},        // R4 ns read on
        '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h0,32'hCAFE0042,1'b0,32'h0,4'd4},        // R4 ns write on
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,32'h0,1'b0,32'hCAFE0042,4'd3},        // R3 enable off
        '{1'b1,1'b1,1'b1,1'b1,1'b0,4'h0,32'h00000002,1'b0,32'h0,4'd8},        // R8 select ch2
        '{1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,32'h0,1'b0,32'h00000002,4'd8},        // R8 read select
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,32'h0,1'b0,32'h0,4'd8},               // R8 ch2 empty
        '{1'b1,1'b0,1'b1,1'b1,1'b0,4'h4,32'h0BAD00F1,1'b0,32'h0,4'd7},        // R7 busy write
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'h4,32'h0,1'b0,32'h0,4'd7},               // R7 dropped
        '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hB,32'h5555AA77,1'b0,32'h0,4'd7},        // R7 others busy
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'hB,32'h0,1'b0,32'h5555AA77,4'd6},        // R6 read back
        '{1'b1,1'b1,1'b0,1'b0,1'b1,4'h0,32'h00000001,1'b1,32'h0,4'd2},        // R2 user select
        '{1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,32'h0,1'b0,32'h00000002,4'd2},        // R2 select kept
        '{1'b1,1'b1,1'b1,1'b1,1'b0,4'h0,32'h00000000,1'b0,32'h0,4'd8}         // R8 select ch0
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge; look at the response one falling edge later.
    task automatic access(input logic wr, input logic tgt, input logic sec, input logic priv,
                          input logic ns, input logic [3:0] act, input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_tgt = tgt; req_secure = sec;
        req_priv = priv; ns_dma_en = ns; chan_active = act; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {30'd0, rsp_valid, rsp_fault, rsp_rdata}, 64'd0);
        chk("R1 asid", {56'd0, asid_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0);
        chk("R1 channel number", {30'd0, rsp_valid, rsp_fault, rsp_rdata}, {30'd0, 2'b10, 32'd0});
        access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0);
        chk("R1 identifier", {30'd0, rsp_valid, rsp_fault, rsp_rdata}, {30'd0, 2'b10, 32'd0});

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].tgt, VEC[i].sec, VEC[i].priv, VEC[i].ns, VEC[i].act, VEC[i].wd);
            chk($sformatf("R%0d vector %0d", VEC[i].rq, i),
                {30'd0, rsp_valid, rsp_fault, rsp_rdata}, {30'd0, 1'b1, VEC[i].ef, VEC[i].ed});
        end

        // R10 ASID of channel 0 (selected by last vector)
        chk("R10 asid ch0", {56'd0, asid_out}, 64'h42);
        // R5 idle cycle after a response: no valid, no fault, zero data
        @(negedge clk);
        chk("R5 idle", {30'd0, rsp_valid, rsp_fault, rsp_rdata}, 64'd0);
        // R5 fault pulse lasts one cycle
        access(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 32'h0);
        chk("R5 fault", {62'd0, rsp_valid, rsp_fault}, 64'd3);
        @(negedge clk);
        chk("R5 fault drop", {62'd0, rsp_valid, rsp_fault}, 64'd0);
        // R6 write then read in the next cycle
        access(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'h7E57C0DE);
        access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0);
        chk("R6 back to back", {32'd0, rsp_rdata}, 64'h7E57C0DE);
        chk("R10 asid new", {56'd0, asid_out}, 64'hDE);
        // R10 switch to channel 2
        access(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 32'h2);
        chk("R10 asid ch2", {56'd0, asid_out}, 64'h77);
        // R9 unimplemented channel 9
        access(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 32'h9);
        chk("R9 asid zero", {56'd0, asid_out}, 64'd0);
        access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0);
        chk("R9 read", {30'd0, rsp_valid, rsp_fault, rsp_rdata}, {30'd0, 2'b10, 32'd0});
        access(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'hFFFFFFFF);
        chk("R9 write no fault", {62'd0, rsp_valid, rsp_fault}, 64'd2);
        access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0);
        chk("R9 still zero", {32'd0, rsp_rdata}, 64'd0);
        for (int c = 0; c < N_CHAN; c++) begin
            logic [31:0] exp_ctx;
            exp_ctx = (c == 0) ? 32'h7E57C0DE : (c == 2) ? 32'h5555AA77 : 32'h0;
            access(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 32'(c));
            access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0);
            chk($sformatf("R9 channel %0d untouched", c), {32'd0, rsp_rdata}, {32'd0, exp_ctx});
        end
        @(negedge clk);
        finish_run();
    end
endmodule